// File: doc/BRIEF.md
# Direction-Gated GPIO Register Block

This block holds the register state of a 32-pin general-purpose I/O port behind a word-wide memory-mapped request port. A pin-level register drives the output values and a direction register (bit set = output) drives the output enables. Software never writes the level register directly. It raises level bits through a write-only set offset and lowers them through a write-only clear offset. Both are gated by the direction register: a set or clear mask that shares no bit with the direction register is refused and reported. A free-form pin-function register is kept for the pin multiplexer.

A two-state machine sequences each access. In `IDLE` the block is ready. A request accepted in `IDLE` updates the registers on that clock edge, captures the response and moves to `RESP`. `RESP` presents the response for exactly one cycle with ready low, then returns to `IDLE`. So the transitions are IDLE→RESP on an accepted request, IDLE→IDLE with no request, and RESP→IDLE always. Three edge-detect offsets accept writes and do nothing. Real edge detection and interrupts are not built, and the nine interrupt lines (eight for single low pins, one for the upper pins together) are held low.

Top module: `gpio_dirgate`

## Requirements
- R1: After reset the level, direction and function registers read 0, `ready_o` is 1, `resp_valid_o` and `err_o` are 0, and `pin_lvl_o` and `pin_oe_o` are 0.
- R2: A request is accepted when `req_i` is high in a cycle where `ready_o` is high. In the cycle after acceptance `resp_valid_o` is 1 for exactly one cycle and `ready_o` is 0 during that cycle.
- R3: Offset 0x04 (direction) and offset 0x20 (pin function) are readable and writable. A read returns the last written value.
- R4: A write to offset 0x08 whose data overlaps the direction register ORs the whole written word into the level register, input bits included.
- R5: A write to offset 0x0C whose data overlaps the direction register clears every written bit in the level register.
- R6: A set or clear write whose data has no bit in common with the direction register leaves the level register unchanged and returns `err_o` = 1.
- R7: Writes to offsets 0x10, 0x14 and 0x18 return no error and change no register.
- R8: Any other access returns `err_o` = 1, `rdata_o` = 0 and changes no register. This covers a write to 0x00, a read of 0x08 through 0x18, any other offset, and any address that is not word-aligned. Offset 0x00 reads the level register.
- R9: All `NUM_IRQ` interrupt outputs stay 0.
- R10: `pin_lvl_o` equals the level register and `pin_oe_o` equals the direction register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Block can accept a request |
| resp_valid_o | output | 1 | Response cycle |
| rdata_o | output | DATA_W | Read data, 0 on writes and errors |
| err_o | output | 1 | Access refused, valid with resp_valid_o |
| pin_lvl_o | output | DATA_W | Pin output levels |
| pin_oe_o | output | DATA_W | Pin output enables |
| irq_o | output | NUM_IRQ | Interrupt lines, held low |

## Verification
Every access is accepted on the rising edge after the driver raises `req_i`. The register change is therefore visible on the pin outputs at the next falling edge, and the response (`resp_valid_o`, `rdata_o`, `err_o`) falls in the single cycle after acceptance. The driver pushes the expected response into a queue when it issues the request. A monitor samples on falling edges and pops an entry only when `resp_valid_o` is high, so each comparison lands in the one response cycle. It also checks that ready is low in that cycle. After each access the driver compares the pin outputs and interrupt lines against its own model at the falling edge that follows acceptance.

// File: rtl/gpio_dirgate_pkg.sv
package gpio_dirgate_pkg;

    localparam int OFS_LEVEL = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_SET   = 'h08;
    localparam int OFS_CLR   = 'h0C;
    localparam int OFS_RISE  = 'h10;
    localparam int OFS_FALL  = 'h14;
    localparam int OFS_EDGE  = 'h18;
    localparam int OFS_FUNC  = 'h20;

    typedef enum logic [3:0] {
        OP_RD_LVL,
        OP_RD_DIR,
        OP_RD_FUNC,
        OP_WR_DIR,
        OP_WR_SET,
        OP_WR_CLR,
        OP_WR_STUB,
        OP_WR_FUNC,
        OP_BAD
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

endpackage

// File: rtl/gpio_dirgate_decode.sv
module gpio_dirgate_decode
    import gpio_dirgate_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o
);

    always_comb begin
        op_o = OP_BAD;
        case (addr_i)
            ADDR_W'(OFS_LEVEL): op_o = we_i ? OP_BAD     : OP_RD_LVL;
            ADDR_W'(OFS_DIR):   op_o = we_i ? OP_WR_DIR  : OP_RD_DIR;
            ADDR_W'(OFS_SET):   op_o = we_i ? OP_WR_SET  : OP_BAD;
            ADDR_W'(OFS_CLR):   op_o = we_i ? OP_WR_CLR  : OP_BAD;
            ADDR_W'(OFS_RISE),
            ADDR_W'(OFS_FALL),
            ADDR_W'(OFS_EDGE):  op_o = we_i ? OP_WR_STUB : OP_BAD;
            ADDR_W'(OFS_FUNC):  op_o = we_i ? OP_WR_FUNC : OP_RD_FUNC;
            default:            op_o = OP_BAD;
        endcase
    end

endmodule

// File: rtl/gpio_dirgate_regs.sv
module gpio_dirgate_regs
    import gpio_dirgate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply_i,
    input  op_e               op_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] level_o,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] func_o,
    output logic              reject_o
);

    logic [DATA_W-1:0] level_q, dir_q, func_q;
    logic              is_gated, overlap;

    assign is_gated = (op_i == OP_WR_SET) || (op_i == OP_WR_CLR);
    assign overlap  = |(wdata_i & dir_q);
    assign reject_o = is_gated && !overlap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
            func_q  <= '0;
        end else if (apply_i) begin
            case (op_i)
                OP_WR_DIR:  dir_q  <= wdata_i;
                OP_WR_FUNC: func_q <= wdata_i;
                OP_WR_SET:  if (overlap) level_q <= level_q | wdata_i;
                OP_WR_CLR:  if (overlap) level_q <= level_q & ~wdata_i;
                default: ;
            endcase
        end
    end

    assign level_o = level_q;
    assign dir_o   = dir_q;
    assign func_o  = func_q;

    // R6: a refused set/clear keeps the level register
    a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && reject_o) |=> $stable(level_q));

    // R4: accepted set leaves every written bit high
    a_r4_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_i == OP_WR_SET && !reject_o) |=> ((level_q & $past(wdata_i)) == $past(wdata_i)));

    // R5: accepted clear leaves every written bit low
    a_r5_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_i == OP_WR_CLR && !reject_o) |=> ((level_q & $past(wdata_i)) == '0));

    // R7: edge-detect stubs change nothing
    a_r7_stub_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_i == OP_WR_STUB) |=> ($stable(level_q) && $stable(dir_q) && $stable(func_q)));

endmodule

// File: rtl/gpio_dirgate_fsm.sv
module gpio_dirgate_fsm
    import gpio_dirgate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  op_e               op_i,
    input  logic              reject_i,
    input  logic [DATA_W-1:0] level_i,
    input  logic [DATA_W-1:0] dir_i,
    input  logic [DATA_W-1:0] func_i,
    output logic              accept_o,
    output logic              ready_o,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    state_e            state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic              err_q, err_now;

    assign ready_o  = (state_q == ST_IDLE);
    assign accept_o = req_i && ready_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        case (op_i)
            OP_RD_LVL:  rd_mux = level_i;
            OP_RD_DIR:  rd_mux = dir_i;
            OP_RD_FUNC: rd_mux = func_i;
            default:    rd_mux = '0;
        endcase
    end

    assign err_now = (op_i == OP_BAD) || reject_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept_o) begin
            rdata_q <= rd_mux;
            err_q   <= err_now;
        end
    end

    assign resp_valid_o = (state_q == ST_RESP);
    assign rdata_o      = resp_valid_o ? rdata_q : '0;
    assign err_o        = resp_valid_o && err_q;

    // R2: response in the cycle after acceptance
    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> resp_valid_o);

    // R2: response lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !resp_valid_o);

    // R8: refused access carries no data
    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

endmodule

// File: rtl/gpio_dirgate.sv
module gpio_dirgate
    import gpio_dirgate_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_IRQ = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               ready_o,
    output logic               resp_valid_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               err_o,
    output logic [DATA_W-1:0]  pin_lvl_o,
    output logic [DATA_W-1:0]  pin_oe_o,
    output logic [NUM_IRQ-1:0] irq_o
);

    op_e               op;
    logic              accept, reject;
    logic [DATA_W-1:0] level, dir, func;

    gpio_dirgate_decode #(.ADDR_W(ADDR_W)) u_decode (
        .we_i   (we_i),
        .addr_i (addr_i),
        .op_o   (op)
    );

    gpio_dirgate_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply_i  (accept),
        .op_i     (op),
        .wdata_i  (wdata_i),
        .level_o  (level),
        .dir_o    (dir),
        .func_o   (func),
        .reject_o (reject)
    );

    gpio_dirgate_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .op_i         (op),
        .reject_i     (reject),
        .level_i      (level),
        .dir_i        (dir),
        .func_i       (func),
        .accept_o     (accept),
        .ready_o      (ready_o),
        .resp_valid_o (resp_valid_o),
        .rdata_o      (rdata_o),
        .err_o        (err_o)
    );

    assign pin_lvl_o = level;
    assign pin_oe_o  = dir;
    assign irq_o     = '0;

endmodule

// File: tb/gpio_dirgate_tb.sv
`timescale 1ns/1ps
module gpio_dirgate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        ready_o, resp_valid_o, err_o;
    logic [31:0] rdata_o, pin_lvl_o, pin_oe_o;
    logic [8:0]  irq_o;

    int total = 0, bad = 0;

    typedef struct {
        logic [31:0] rd;
        logic        er;
        string       tag;
    } exp_t;
    exp_t exq[$];

    logic [31:0] lvl_m = '0, dir_m = '0, fn_m = '0;

    always #2.5 clk = ~clk;

    gpio_dirgate u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .ready_o(ready_o), .resp_valid_o(resp_valid_o),
        .rdata_o(rdata_o), .err_o(err_o), .pin_lvl_o(pin_lvl_o),
        .pin_oe_o(pin_oe_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected response per response cycle
    always @(negedge clk) begin
        if (rst_n && resp_valid_o) begin
            check(!ready_o, "R2 ready low in response", {31'b0, ready_o}, 32'h0);
            if (exq.size() == 0) begin
                check(1'b0, "R2 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                check(rdata_o == e.rd, {e.tag, " rdata"}, rdata_o, e.rd);
                check(err_o == e.er, {e.tag, " err"}, {31'b0, err_o}, {31'b0, e.er});
            end
        end
    end

    task automatic pins(input string tag);
        check(pin_lvl_o == lvl_m, {tag, " R10 level pins"}, pin_lvl_o, lvl_m);
        check(pin_oe_o == dir_m, {tag, " R10 enable pins"}, pin_oe_o, dir_m);
        check(irq_o == '0, {tag, " R9 irq low"}, {23'b0, irq_o}, 32'h0);
    endtask

    task automatic access(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        logic ovl;
        e.rd = '0; e.er = 1'b0; e.tag = tag;
        ovl = |(d & dir_m);
        if (!we) begin
            if (a == 8'h00)      e.rd = lvl_m;
            else if (a == 8'h04) e.rd = dir_m;
            else if (a == 8'h20) e.rd = fn_m;
            else                 e.er = 1'b1;
        end else begin
            case (a)
                8'h04: dir_m = d;
                8'h20: fn_m = d;
                8'h08: if (ovl) lvl_m = lvl_m | d; else e.er = 1'b1;
                8'h0C: if (ovl) lvl_m = lvl_m & ~d; else e.er = 1'b1;
                8'h10, 8'h14, 8'h18: ;
                default: e.er = 1'b1;
            endcase
        end
        exq.push_back(e);
        @(negedge clk);
        req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        pins(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready_o == 1'b1, "R1 ready in reset", {31'b0, ready_o}, 32'h1);
        check(resp_valid_o == 1'b0, "R1 no response in reset", {31'b0, resp_valid_o}, 32'h0);
        pins("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 8'h00, 0, "R1 level after reset");
        access(1'b0, 8'h04, 0, "R1 dir after reset");
        access(1'b0, 8'h20, 0, "R1 func after reset");
        // R3 register access
        access(1'b1, 8'h04, 32'h0000_FFFF, "R3 dir write");
        access(1'b0, 8'h04, 0, "R3 dir read");
        access(1'b1, 8'h20, 32'hA5A5_0001, "R3 func write");
        access(1'b0, 8'h20, 0, "R3 func read");
        // R4 set
        access(1'b1, 8'h08, 32'h0000_00F0, "R4 set outputs");
        access(1'b1, 8'h08, 32'h0003_0001, "R4 set with input bits");
        access(1'b0, 8'h00, 0, "R4 level read");
        // R6 refused set
        access(1'b1, 8'h08, 32'hFFFF_0000, "R6 set inputs only");
        // R5 clear
        access(1'b1, 8'h0C, 32'h0000_0030, "R5 clear outputs");
        access(1'b1, 8'h0C, 32'h0003_0000, "R6 clear inputs only");
        access(1'b0, 8'h00, 0, "R5 level read");
        // R7 stubs
        access(1'b1, 8'h10, 32'hFFFF_FFFF, "R7 rise stub");
        access(1'b1, 8'h14, 32'hFFFF_FFFF, "R7 fall stub");
        access(1'b1, 8'h18, 32'hFFFF_FFFF, "R7 edge stub");
        access(1'b0, 8'h04, 0, "R7 dir unchanged");
        access(1'b0, 8'h20, 0, "R7 func unchanged");
        // R8 unknown accesses
        access(1'b1, 8'h00, 32'hFFFF_FFFF, "R8 write level");
        access(1'b0, 8'h08, 0, "R8 read set");
        access(1'b0, 8'h18, 0, "R8 read edge stub");
        access(1'b0, 8'h1C, 0, "R8 read hole");
        access(1'b1, 8'h1C, 32'h1234_5678, "R8 write hole");
        access(1'b0, 8'h02, 0, "R8 misaligned");
        access(1'b0, 8'h00, 0, "R8 level unchanged");
        // R6 with all inputs
        access(1'b1, 8'h04, 32'h0, "R3 dir cleared");
        access(1'b1, 8'h08, 32'hFFFF_FFFF, "R6 set with no outputs");
        access(1'b1, 8'h0C, 32'hFFFF_FFFF, "R6 clear with no outputs");
        access(1'b1, 8'h04, 32'h8000_0000, "R3 dir top bit");
        access(1'b1, 8'h0C, 32'hFFFF_FFFF, "R5 clear all");
        access(1'b0, 8'h00, 0, "R5 level zero");
        repeat (3) @(negedge clk);
        check(exq.size() == 0, "R2 all responses seen", exq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule